// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register Bank

This block holds the 32-bit control and status words of a DRAM controller, reached through a 4 KB window of word addresses. A small state machine sets how far software may write to the bank. Word 0 holds a protection key. Writing the open key to word 0 makes the whole bank writable. Writing any other value puts the bank back into a soft lock, in which only word 0 accepts writes. In the revision-3 build, a second key sets a permanent lock that rejects every write until reset.

The configuration word at word 1 always keeps its hardware-defined fields, whatever software writes to it. Those fields are the revision number, the graphics aperture code, the initialisation-done flag and the DRAM size code. Writes to the PHY status word and to the ECC self-test word are reshaped, so the PHY never reports busy and the self-test always reports a pass. Parameters set the revision (1 or 3), the installed DRAM size and the depth of the bank.

Top module: `dramctl_regbank`

## Requirements
- R1: After reset, word 0 reads 0x00000000 (soft-locked), word 1 reads its fixed fields only, and every other word reads 0. No error or read-valid pulse is present.
- R2: A write of 0xFC600309 to word 0 makes word 0 read 0x00000001 (open). Any other value written to word 0 makes it read 0x00000000 (soft-locked).
- R3: While soft-locked, a write to any word other than word 0 leaves that word unchanged, and `bus_err` is high in the cycle after the write.
- R4: When HW_REV is 3, a write of 0xDEADDEAD to word 0 makes word 0 read 0x00000010. From then on every write, including one to word 0, is dropped and raises `bus_err`, until reset.
- R5: A write to word 1 stores (data AND NOT 0xF00FC04C) OR fixed. The cleared mask covers bits 31:28, 19, 18:14, 6 and 3:2. Written bits 1:0 are ORed with the size code.
- R6: The fixed fields of word 1 are as follows. Bits 31:28 hold HW_REV and bits 3:2 hold 2'b11. Bit 19 is 1 only when HW_REV is 1. Bits 1:0 hold log2(DRAM_MB / base), where the base is 128 MB for revision 1 and 256 MB for revision 3.
- R7: A write to word 24 (byte offset 0x60) clears bit 0. When HW_REV is 3, it also sets bit 4.
- R8: A write to word 28 (byte offset 0x70) sets bit 12 and clears bit 13.
- R9: While open, a write to any other in-range word stores the data unchanged.
- R10: A read of a word index at or above DEPTH returns 0. A write there changes nothing and raises `bus_err`.
- R11: `bus_rvalid` and `bus_rdata` appear exactly one cycle after a read request, and `bus_rvalid` stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 11:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_err | output | 1 | One-cycle pulse for a dropped write |

## Verification
The checker takes each request as a single-cycle pulse with a fixed direction and a word-aligned address. It also assumes reset is held for at least one clock edge before traffic starts. The stimulus follows these rules: it raises `bus_valid` for one cycle per access, changes inputs only on falling edges, and leaves `bus_addr[1:0]` at zero. The sequence walks the lock through soft, open, soft again, hard and back to reset, so that every branch of the lock gating is reached from a known state.

// File: rtl/dramctl_regbank_pkg.sv
package dramctl_regbank_pkg;

   typedef enum logic [1:0] {
      LK_SOFT = 2'd0,
      LK_OPEN = 2'd1,
      LK_HARD = 2'd2
   } lock_e;

   localparam logic [31:0] KEY_OPEN   = 32'hFC60_0309;
   localparam logic [31:0] KEY_HARD   = 32'hDEAD_DEAD;
   localparam logic [31:0] PROT_SOFT  = 32'h0000_0000;
   localparam logic [31:0] PROT_OPEN  = 32'h0000_0001;
   localparam logic [31:0] PROT_HARD  = 32'h0000_0010;

   localparam int IDX_KEY  = 0;
   localparam int IDX_CONF = 1;
   localparam int IDX_STAT = 24;
   localparam int IDX_ECC  = 28;

   // bits cleared from every configuration write before fixed fields are merged
   localparam logic [31:0] CONF_RO_MASK = 32'hF00F_C04C;

   function automatic logic [31:0] conf_fixed(input int rev, input logic [1:0] code);
      logic [31:0] v;
      v        = '0;
      v[31:28] = 4'(rev);
      v[19]    = (rev == 1);
      v[3:2]   = 2'b11;
      v[1:0]   = code;
      return v;
   endfunction

   // returns -1 for an illegal size
   function automatic int size_code(input int base_mb, input int mb);
      int c;
      c = -1;
      for (int i = 0; i < 4; i++) begin
         if (mb == (base_mb << i)) c = i;
      end
      return c;
   endfunction

endpackage

// File: rtl/dramctl_keylock.sv
module dramctl_keylock
   import dramctl_regbank_pkg::*;
#(
   parameter bit HARD_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_we,
   input  logic [31:0] key_data,
   output lock_e       lock_q,
   output logic [31:0] prot_word
);

   lock_e lock_d;

   always_comb begin
      lock_d = LK_SOFT;
      if (key_data == KEY_OPEN) begin
         lock_d = LK_OPEN;
      end else if (HARD_EN && (key_data == KEY_HARD)) begin
         lock_d = LK_HARD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= LK_SOFT;
      end else if (key_we) begin
         lock_q <= lock_d;
      end
   end

   always_comb begin
      case (lock_q)
         LK_OPEN: prot_word = PROT_OPEN;
         LK_HARD: prot_word = PROT_HARD;
         default: prot_word = PROT_SOFT;
      endcase
   end

endmodule

// File: rtl/dramctl_wrshape.sv
module dramctl_wrshape
   import dramctl_regbank_pkg::*;
#(
   parameter int         HW_REV = 3,
   parameter logic [1:0] CODE   = 2'd0,
   parameter int         AW     = 6
) (
   input  logic [AW-1:0] idx,
   input  logic [31:0]   din,
   output logic [31:0]   dout
);

   localparam logic [31:0] FIXED = conf_fixed(HW_REV, CODE);

   logic [31:0] stat_v;

   generate
      if (HW_REV == 3) begin : g_pll_forced
         assign stat_v = (din & ~32'h0000_0001) | 32'h0000_0010;
      end else begin : g_pll_free
         assign stat_v = din & ~32'h0000_0001;
      end
   endgenerate

   always_comb begin
      if (idx == AW'(IDX_CONF)) begin
         dout = (din & ~CONF_RO_MASK) | FIXED;
      end else if (idx == AW'(IDX_STAT)) begin
         dout = stat_v;
      end else if (idx == AW'(IDX_ECC)) begin
         dout = (din | 32'h0000_1000) & ~32'h0000_2000;
      end else begin
         dout = din;
      end
   end

endmodule

// File: rtl/dramctl_regarray.sv
module dramctl_regarray
   import dramctl_regbank_pkg::*;
#(
   parameter int          DEPTH    = 64,
   parameter int          AW       = 6,
   parameter logic [31:0] CONF_RST = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] widx,
   input  logic [31:0]   wdata,
   input  logic [AW-1:0] ridx,
   output logic [31:0]   rdata
);

   logic [31:0] regs_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            regs_q[i] <= (i == IDX_CONF) ? CONF_RST : 32'h0;
         end
      end else if (we) begin
         regs_q[widx] <= wdata;
      end
   end

   assign rdata = regs_q[ridx];

endmodule

// File: rtl/dramctl_regbank.sv
module dramctl_regbank
   import dramctl_regbank_pkg::*;
#(
   parameter int HW_REV  = 3,
   parameter int DRAM_MB = 1024,
   parameter int DEPTH   = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_valid,
   input  logic        bus_write,
   input  logic [11:0] bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        bus_rvalid,
   output logic        bus_err
);

   localparam int          BASE_MB   = (HW_REV == 1) ? 128 : 256;
   localparam int          SZ        = size_code(BASE_MB, DRAM_MB);
   localparam logic [1:0]  CODE      = 2'(SZ);
   localparam int          AW        = $clog2(DEPTH);
   localparam bit          HARD_EN   = (HW_REV == 3);
   localparam logic [31:0] CONF_RST  = conf_fixed(HW_REV, CODE);

   generate
      if (HW_REV != 1 && HW_REV != 3) begin : g_bad_rev
         $error("dramctl_regbank: HW_REV must be 1 or 3");
      end
      if (SZ < 0) begin : g_bad_size
         $error("dramctl_regbank: DRAM_MB is not a legal size for this revision");
      end
      if (DEPTH < IDX_ECC + 1 || DEPTH > 1024) begin : g_bad_depth
         $error("dramctl_regbank: DEPTH must lie in 29..1024");
      end
   endgenerate

   logic [9:0]    word_idx;
   logic          in_rng;
   logic          is_key;
   logic [AW-1:0] arr_idx;
   logic          wr_req;
   logic          rd_req;
   logic          wr_ok;
   lock_e         lock_q;
   logic [31:0]   prot_word;
   logic [31:0]   shaped;
   logic [31:0]   arr_rdata;
   logic [31:0]   rdata_d;

   assign word_idx = bus_addr[11:2];
   assign in_rng   = ({1'b0, word_idx} < 11'(DEPTH));
   assign is_key   = (word_idx == 10'(IDX_KEY));
   assign arr_idx  = word_idx[AW-1:0];
   assign wr_req   = bus_valid & bus_write;
   assign rd_req   = bus_valid & ~bus_write;

   // gating by lock state: open admits all, soft admits only the key word
   always_comb begin
      wr_ok = 1'b0;
      if (wr_req && in_rng) begin
         case (lock_q)
            LK_OPEN: wr_ok = 1'b1;
            LK_SOFT: wr_ok = is_key;
            default: wr_ok = 1'b0;
         endcase
      end
   end

   dramctl_keylock #(
      .HARD_EN (HARD_EN)
   ) u_keylock (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_we    (wr_ok & is_key),
      .key_data  (bus_wdata),
      .lock_q    (lock_q),
      .prot_word (prot_word)
   );

   dramctl_wrshape #(
      .HW_REV (HW_REV),
      .CODE   (CODE),
      .AW     (AW)
   ) u_wrshape (
      .idx  (arr_idx),
      .din  (bus_wdata),
      .dout (shaped)
   );

   dramctl_regarray #(
      .DEPTH    (DEPTH),
      .AW       (AW),
      .CONF_RST (CONF_RST)
   ) u_regarray (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok & ~is_key),
      .widx  (arr_idx),
      .wdata (shaped),
      .ridx  (arr_idx),
      .rdata (arr_rdata)
   );

   always_comb begin
      if (!in_rng) begin
         rdata_d = 32'h0;
      end else if (is_key) begin
         rdata_d = prot_word;
      end else begin
         rdata_d = arr_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= 32'h0;
         bus_rvalid <= 1'b0;
         bus_err    <= 1'b0;
      end else begin
         bus_rvalid <= rd_req;
         bus_err    <= wr_req & ~wr_ok;
         if (rd_req) bus_rdata <= rdata_d;
      end
   end

endmodule

// File: rtl/dramctl_regbank_chk.sv
module dramctl_regbank_chk
   import dramctl_regbank_pkg::*;
#(
   parameter int HW_REV = 3,
   parameter int DEPTH  = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_valid,
   input logic        bus_write,
   input logic [11:0] bus_addr,
   input logic [31:0] bus_rdata,
   input logic        bus_rvalid,
   input logic        bus_err,
   input lock_e       lock_q
);

   logic rd_req;
   logic wr_req;
   logic oor;
   assign rd_req = bus_valid && !bus_write;
   assign wr_req = bus_valid && bus_write;
   assign oor    = ({1'b0, bus_addr[11:2]} >= 11'(DEPTH));

   p_soft_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && lock_q == LK_SOFT && bus_addr[11:2] != 10'd0) |=> bus_err);

   p_hard_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q == LK_HARD) |=> (lock_q == LK_HARD));

   p_hard_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && lock_q == LK_HARD) |=> bus_err);

   p_conf_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && bus_addr[11:2] == 10'd1) |=>
         (bus_rdata[31:28] == 4'(HW_REV) && bus_rdata[3:2] == 2'b11));

   p_oor_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && oor) |=> (bus_rdata == 32'h0));

   p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> bus_rvalid);

   p_no_spurious_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !bus_rvalid);

endmodule

bind dramctl_regbank dramctl_regbank_chk #(
   .HW_REV (HW_REV),
   .DEPTH  (DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .bus_err    (bus_err),
   .lock_q     (lock_q)
);

// File: tb/dramctl_regbank_bench.sv
module dramctl_regbank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        bus_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   dramctl_regbank #(
      .HW_REV  (3),
      .DRAM_MB (1024),
      .DEPTH   (64)
   ) u_dramctl_regbank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_valid  (bus_valid),
      .bus_write  (bus_write),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .bus_err    (bus_err)
   );

   // fixed word 1 for revision 3, 1024 MB on a 256 MB base: code 2
   localparam logic [31:0] CONF_FIX = 32'h3000_000E;

   // monitor: pops expected read data when the design answers
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R11 unexpected rvalid, actual data %08h expected none", bus_rdata);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_bad++;
               $display("FAIL %s read data actual %08h expected %08h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit exp_err,
                     input string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      n_chk++;
      if (bus_err !== exp_err) begin
         n_bad++;
         $display("FAIL %s err after write to %03h actual %b expected %b", tag, a, bus_err, exp_err);
      end
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      n_chk++;
      if (bus_err !== 1'b0 || bus_rvalid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 outputs after reset actual err=%b rvalid=%b expected 0 0", bus_err, bus_rvalid);
      end
      rd(12'h000, 32'h0, "R1");
      rd(12'h004, CONF_FIX, "R1");
      rd(12'h060, 32'h0, "R1");

      // soft-locked: non-key writes dropped
      wr(12'h040, 32'h1234_5678, 1'b1, "R3");
      rd(12'h040, 32'h0, "R3");

      // unlock
      wr(12'h000, 32'hFC60_0309, 1'b0, "R2");
      rd(12'h000, 32'h0000_0001, "R2");

      // plain words
      wr(12'h040, 32'h1234_5678, 1'b0, "R9");
      rd(12'h040, 32'h1234_5678, "R9");
      wr(12'h044, 32'hA5A5_0F0F, 1'b0, "R9");
      rd(12'h044, 32'hA5A5_0F0F, "R9");

      // configuration masking and fixed fields
      wr(12'h004, 32'hFFFF_FFFF, 1'b0, "R5");
      rd(12'h004, 32'h3FF0_3FBF, "R5");
      wr(12'h004, 32'h0000_0000, 1'b0, "R6");
      rd(12'h004, CONF_FIX, "R6");
      wr(12'h004, 32'h0000_0001, 1'b0, "R5");
      rd(12'h004, 32'h3000_000F, "R5");

      // PHY status
      wr(12'h060, 32'hFFFF_FFFF, 1'b0, "R7");
      rd(12'h060, 32'hFFFF_FFFE, "R7");
      wr(12'h060, 32'h0000_0001, 1'b0, "R7");
      rd(12'h060, 32'h0000_0010, "R7");

      // ECC self-test
      wr(12'h070, 32'h0000_2000, 1'b0, "R8");
      rd(12'h070, 32'h0000_1000, "R8");
      wr(12'h070, 32'hFFFF_FFFF, 1'b0, "R8");
      rd(12'h070, 32'hFFFF_DFFF, "R8");

      // out of range
      rd(12'h100, 32'h0, "R10");
      rd(12'hFFC, 32'h0, "R10");
      wr(12'h100, 32'hFFFF_FFFF, 1'b1, "R10");
      rd(12'h100, 32'h0, "R10");

      // relock with an arbitrary value
      wr(12'h000, 32'h1234_5678, 1'b0, "R2");
      rd(12'h000, 32'h0, "R2");
      wr(12'h040, 32'h0, 1'b1, "R3");
      rd(12'h040, 32'h1234_5678, "R3");

      // hard lock
      wr(12'h000, 32'hFC60_0309, 1'b0, "R2");
      wr(12'h000, 32'hDEAD_DEAD, 1'b0, "R4");
      rd(12'h000, 32'h0000_0010, "R4");
      wr(12'h000, 32'hFC60_0309, 1'b1, "R4");
      rd(12'h000, 32'h0000_0010, "R4");
      wr(12'h040, 32'h0, 1'b1, "R4");
      rd(12'h040, 32'h1234_5678, "R4");

      // reset releases the hard lock
      do_reset();
      rd(12'h000, 32'h0, "R4");
      rd(12'h040, 32'h0, "R1");
      rd(12'h004, CONF_FIX, "R1");

      repeat (3) @(negedge clk);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R11 missing read responses actual %0d pending expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule